// File: doc/BRIEF.md
# Select-Controlled Signature Register

This block is a clocked 32-bit multiple-input signature register that folds a measured-data word into a running signature. It listens to the same 5-bit function select that drives a neighbouring ALU. It acts on four control codes of its own: halt, seed load, single step and restart. Every other code leaves its mode as it was. The current signature is always visible on a 32-bit output.

The register has two modes, stopped and running. In running mode it performs one compression on every rising clock edge. In stopped mode it holds its contents, and only the step code makes it compress once. After a synchronous active-low reset it sits in stopped mode with the seed value loaded.

One compression works on the current signature S[31:0] and the data word D[31:0]. A feedback bit is formed as F = S[31]^S[21]^S[1]^S[0], which is the polynomial x^32+x^22+x^2+x+1. The next signature is {S[30:0], F} XOR D.

Top module: `sig_capture_reg`

## Requirements
- R1: While rst_n is low at a rising edge, the next signature is 32'h00000001 and the mode becomes stopped.
- R2: In running mode, a rising edge with any select code other than 00001, 00010, 01000 or 10000 performs one compression as defined above and keeps running mode.
- R3: Select code 00001 at a rising edge leaves the signature unchanged and puts the register in stopped mode.
- R4: Select code 00010 at a rising edge loads 32'h00000001 and leaves the mode unchanged.
- R5: Select code 01000 at a rising edge performs exactly one compression in either mode and leaves the mode unchanged.
- R6: Select code 10000 at a rising edge loads 32'h00000001 and puts the register in running mode.
- R7: In stopped mode, a rising edge with any select code other than 00010, 01000 or 10000 leaves the signature unchanged and keeps stopped mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 5 | Shared function select |
| meas_data | input | 32 | Measured data folded in on each compression |
| sig_out | output | 32 | Current signature |

## Verification
The assertions assume that sel and meas_data are stable and known at each rising edge. They also assume that the only way to tell the mode from outside is by how the signature behaves on later cycles. The bench meets this by changing inputs only on the falling edge and never driving X. Every one of the 32 select codes is swept from both modes, with data patterns chosen so that both the shift and the data XOR matter. A follow-up cycle after each code then shows at the output which mode the register is left in.

// File: rtl/sig_pkg.sv
// Package: shared mode type and default control codes for the signature register.
// Assumes: a single-bit mode is enough (stopped or running).
package sig_pkg;
    typedef enum logic {
        MODE_STOPPED = 1'b0,
        MODE_RUNNING = 1'b1
    } sig_mode_e;

    localparam int          DEF_SEL_W     = 5;
    localparam logic [4:0]  DEF_CODE_HALT = 5'b00001;
    localparam logic [4:0]  DEF_CODE_SEED = 5'b00010;
    localparam logic [4:0]  DEF_CODE_STEP = 5'b01000;
    localparam logic [4:0]  DEF_CODE_RST  = 5'b10000;
endpackage

// File: rtl/sig_mode_ctrl.sv
// Module: decodes the shared select into control strobes and keeps the mode.
// Assumes: sel is fully decoded; codes are distinct; reset is synchronous, active low.
module sig_mode_ctrl
    import sig_pkg::*;
#(
    parameter int             SEL_W     = DEF_SEL_W,
    parameter logic [SEL_W-1:0] CODE_HALT = DEF_CODE_HALT,
    parameter logic [SEL_W-1:0] CODE_SEED = DEF_CODE_SEED,
    parameter logic [SEL_W-1:0] CODE_STEP = DEF_CODE_STEP,
    parameter logic [SEL_W-1:0] CODE_RST  = DEF_CODE_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output sig_mode_e        mode_q,
    output logic             do_load,
    output logic             do_compress
);
    logic is_halt, is_seed, is_step, is_rst;
    sig_mode_e mode_d;

    // Full decode of the four control codes.
    always_comb begin
        is_halt = (sel == CODE_HALT);
        is_seed = (sel == CODE_SEED);
        is_step = (sel == CODE_STEP);
        is_rst  = (sel == CODE_RST);
    end

    // Strobes for the state register: load seed, or compress once.
    always_comb begin
        do_load     = is_seed | is_rst;
        do_compress = is_step |
                      ((mode_q == MODE_RUNNING) & ~is_halt & ~is_seed & ~is_rst);
    end

    // Next mode: halt stops, restart runs, everything else keeps.
    always_comb begin
        mode_d = mode_q;
        if (is_halt)     mode_d = MODE_STOPPED;
        else if (is_rst) mode_d = MODE_RUNNING;
    end

    // Mode register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_STOPPED;
        else        mode_q <= mode_d;
    end

    // R3
    halt_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CODE_HALT) |=> (mode_q == MODE_STOPPED));
    // R6
    restart_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CODE_RST) |=> (mode_q == MODE_RUNNING));
    // R4
    seed_mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel == CODE_SEED) || (sel == CODE_STEP)) |=> $stable(mode_q));
    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_load && do_compress));
endmodule

// File: rtl/sig_compress.sv
// Module: one combinational compression step of the signature.
// Assumes: TAP_MASK marks the feedback bits; the top bit must be set.
module sig_compress #(
    parameter int               WIDTH    = 32,
    parameter logic [WIDTH-1:0] TAP_MASK = 32'h8020_0003
) (
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] data,
    output logic [WIDTH-1:0] nxt
);
    logic             fb;
    logic [WIDTH-1:0] shifted;

    // Feedback parity over the tapped bits.
    always_comb fb = ^(cur & TAP_MASK);

    // Shift toward the top, feedback entering at bit 0.
    assign shifted[0] = fb;
    for (genvar i = 1; i < WIDTH; i++) begin : g_shift
        assign shifted[i] = cur[i-1];
    end

    // Fold the measured word into the shifted state.
    for (genvar j = 0; j < WIDTH; j++) begin : g_fold
        assign nxt[j] = shifted[j] ^ data[j];
    end
endmodule

// File: rtl/sig_state_reg.sv
// Module: signature state register with seed load and compress enables.
// Assumes: load and compress are never both high; reset is synchronous, active low.
module sig_state_reg #(
    parameter int               WIDTH = 32,
    parameter logic [WIDTH-1:0] SEED  = 32'h0000_0001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             compress,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] sig_q
);
    // Update the signature: reset or load to seed, compress, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)        sig_q <= SEED;
        else if (load)     sig_q <= SEED;
        else if (compress) sig_q <= nxt;
    end

    // R1
    reset_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sig_q == SEED));
    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sig_q == SEED));
    // R5
    compress_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (compress && !load) |=> (sig_q == $past(nxt)));
endmodule

// File: rtl/sig_capture_reg.sv
// Module: top of the select-controlled signature register.
// Assumes: sel is shared with an ALU; only the four control codes act here.
module sig_capture_reg
    import sig_pkg::*;
#(
    parameter int               WIDTH     = 32,
    parameter int               SEL_W     = DEF_SEL_W,
    parameter logic [WIDTH-1:0] SEED      = 32'h0000_0001,
    parameter logic [WIDTH-1:0] TAP_MASK  = 32'h8020_0003,
    parameter logic [SEL_W-1:0] CODE_HALT = DEF_CODE_HALT,
    parameter logic [SEL_W-1:0] CODE_SEED = DEF_CODE_SEED,
    parameter logic [SEL_W-1:0] CODE_STEP = DEF_CODE_STEP,
    parameter logic [SEL_W-1:0] CODE_RST  = DEF_CODE_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [WIDTH-1:0] meas_data,
    output logic [WIDTH-1:0] sig_out
);
    sig_mode_e        mode_q;
    logic             do_load, do_compress;
    logic [WIDTH-1:0] sig_q, sig_nxt;

    sig_mode_ctrl #(
        .SEL_W(SEL_W), .CODE_HALT(CODE_HALT), .CODE_SEED(CODE_SEED),
        .CODE_STEP(CODE_STEP), .CODE_RST(CODE_RST)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .mode_q(mode_q), .do_load(do_load), .do_compress(do_compress)
    );

    sig_compress #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_comp (
        .cur(sig_q), .data(meas_data), .nxt(sig_nxt)
    );

    sig_state_reg #(.WIDTH(WIDTH), .SEED(SEED)) u_state (
        .clk(clk), .rst_n(rst_n), .load(do_load), .compress(do_compress),
        .nxt(sig_nxt), .sig_q(sig_q)
    );

    assign sig_out = sig_q;

    // R7
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_STOPPED) && (sel != CODE_SEED) && (sel != CODE_STEP)
         && (sel != CODE_RST)) |=> $stable(sig_out));
    // R3
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == CODE_HALT) |=> $stable(sig_out));
    // R2
    run_compress_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == MODE_RUNNING) && (sel != CODE_HALT) && (sel != CODE_SEED)
         && (sel != CODE_RST)) |=> (sig_out == $past(sig_nxt)));
endmodule

// File: tb/sig_capture_reg_bench.sv
// Bench: sweeps every select code from both modes against an arithmetic model.
module sig_capture_reg_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  sel = 5'd0;
    logic [31:0] meas_data = 32'd0;
    logic [31:0] sig_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] exp_sig = 32'h1;
    bit          exp_run = 1'b0;
    bit          done    = 1'b0;

    always #2 clk = ~clk;

    sig_capture_reg u_sig_capture_reg (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .meas_data(meas_data), .sig_out(sig_out)
    );

    function automatic logic [31:0] model_step(logic [31:0] s, logic [31:0] d);
        logic f;
        f = s[31] ^ s[21] ^ s[1] ^ s[0];
        return {s[30:0], f} ^ d;
    endfunction

    task automatic check(string tag, logic [31:0] exp);
        n_checks++;
        if (sig_out !== exp) begin
            n_fail++;
            $display("FAIL %s: sig_out=%h expected=%h", tag, sig_out, exp);
        end
    endtask

    // Apply one code for one edge, update the model, compare after the edge.
    task automatic apply(logic [4:0] c, logic [31:0] d);
        string tag;
        @(negedge clk);
        sel = c; meas_data = d;
        case (c)
            5'b00001: begin tag = "R3"; exp_run = 1'b0; end
            5'b00010: begin tag = "R4"; exp_sig = 32'h1; end
            5'b01000: begin tag = "R5"; exp_sig = model_step(exp_sig, d); end
            5'b10000: begin tag = "R6"; exp_sig = 32'h1; exp_run = 1'b1; end
            default: begin
                if (exp_run) begin tag = "R2"; exp_sig = model_step(exp_sig, d); end
                else tag = "R7";
            end
        endcase
        @(posedge clk); #1;
        check(tag, exp_sig);
    endtask

    initial begin
        logic [31:0] gen;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 check("R1", 32'h1);
        @(negedge clk) rst_n = 1'b1;
        // After reset the register must be stopped: a neutral code holds it.
        apply(5'b00000, 32'hDEAD_BEEF);
        apply(5'b10010, 32'h1234_5678);

        gen = 32'hACE1_2468;
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 32; c++) begin
                // Put the register in the wanted mode with a non-trivial signature.
                apply(5'b10000, 32'h0);
                apply(5'b00011, 32'hF0F0_0F0F);
                apply(5'b01010, 32'h8000_0001);
                if (m == 0) apply(5'b00001, 32'h5555_AAAA);
                gen = model_step(gen, 32'h0);
                apply(5'(c), gen);
                // Follow-up cycles reveal the mode left behind.
                apply(5'b00000, 32'h0F1E_2D3C);
                apply(5'b11110, ~gen);
            end
        end

        // Long running stretch with changing data, then halt and single steps.
        apply(5'b10000, 32'h0);
        for (int k = 0; k < 200; k++) begin
            gen = model_step(gen, 32'h0);
            apply((k % 2 == 0) ? 5'b01111 : 5'b00101, gen);
        end
        apply(5'b00001, 32'hFFFF_FFFF);
        for (int k = 0; k < 8; k++) apply(5'b01000, 32'(k) << (k * 3));
        apply(5'b00010, 32'hFFFF_FFFF);
        apply(5'b01000, 32'h0);

        // Reset in running mode returns to seed and stopped.
        apply(5'b10000, 32'h0);
        apply(5'b00000, 32'h7);
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk); #1;
        exp_sig = 32'h1; exp_run = 1'b0;
        check("R1", exp_sig);
        @(negedge clk) rst_n = 1'b1;
        apply(5'b00000, 32'hCAFE_F00D);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule